// File: doc/BRIEF.md
# Write-one set/clear mode control register

This block holds the host-visible mode byte of a fieldbus slave interface controller. A host CPU writes to it over a small parallel bus. One bus address turns on every bit position written as 1, and a second address turns off every position written as 1. Positions written as 0 keep their value, so the host can change one bit without reading the byte first.

Five of the six implemented bits are commands. The host sets a command bit, the block carries out the action, and the block then clears the bit. The commands are: leave offline for passive-idle and start the timers, acknowledge the interrupt, return to offline once the protocol engine is idle, force the protocol state machine back to its parameter-wait state, and reload the user watchdog. The sixth bit is a plain level enable. It decides whether a configuration-okay event from the protocol engine swaps the configuration buffers. The protocol engine appears here only as a busy input, a configuration-okay input and the strobes it receives.

Top module: `setclr_mode_ctrl`

## Requirements
- R1: A write to address 0x08 sets every implemented bit written as 1. The bits are 0 start, 1 end-of-interrupt, 2 go-offline, 3 leave-master, 4 buffer-swap enable and 5 watchdog reload. Bits written as 0 keep their value, and the new value appears on `mode_o` one clock after the write.
- R2: A write to address 0x09 clears every bit written as 1 and leaves the bits written as 0 unchanged. This includes a pending go-offline request, which is then withdrawn.
- R3: Bits 7 and 6 of `mode_o` always read 0. Writes to any address other than 0x08 or 0x09 change nothing.
- R4: After reset, `mode_o` is 0, the controller is offline (`online_o` = 0) and all strobes are low.
- R5: When bit 0 is 1, the next clock sets `online_o`, pulses `timer_start_o` for one cycle, clears bit 0 and forces bit 2 to 0.
- R6: When bit 1 is 1, the next clock pulses `eoi_o` for one cycle and clears bit 1.
- R7: When bit 3 is 1, the next clock pulses `leave_master_o` for one cycle and clears bit 3.
- R8: When bit 5 is 1, the next clock pulses `wd_reload_o`, loads `wd_preset_i` into `wd_value_o` and clears bit 5.
- R9: While bit 2 is 1 and `busy_i` is high, bit 2 stays 1 and `online_o` does not change. On the first clock with `busy_i` low, `online_o` goes to 0 and bit 2 clears.
- R10: Bit 4 does not clear itself. `cfg_swap_o` equals `cfg_ok_i` while bit 4 is 1 and stays 0 while bit 4 is 0.
- R11: If the host sets a command bit in the same cycle that the block clears it, the bit stays 1 and its action, with its strobe, happens again on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 8 | Host write address |
| bus_wdata | input | 8 | Host write data |
| busy_i | input | 1 | Protocol engine is handling a request |
| cfg_ok_i | input | 1 | Configuration-okay event |
| wd_preset_i | input | 16 | Watchdog reload value |
| mode_o | output | 8 | Current mode byte |
| online_o | output | 1 | 1 when passive-idle or later, 0 when offline |
| timer_start_o | output | 1 | Pulse that starts the idle and watchdog timers |
| eoi_o | output | 1 | Pulse that drives the interrupt outputs inactive |
| leave_master_o | output | 1 | Pulse that forces the parameter-wait state |
| wd_reload_o | output | 1 | Pulse that reloads the user watchdog |
| wd_value_o | output | 16 | Value captured at the last reload |
| cfg_swap_o | output | 1 | Swap the configuration buffers |

## Verification
The bench holds a go-offline request while the engine stays busy. A design that acts on the request at once would drop `online_o` early, and one that never acts would stay online after the engine goes idle. It then sends a start command while a go-offline is pending, and separately withdraws a pending go-offline with a clear write; a design that gets either wrong goes offline when it should not. It re-sets an end-of-interrupt bit in the exact cycle the block clears it. A design whose self-clear wins over the host would produce one strobe instead of two. It also writes reserved bits, writes to stray addresses and clears with zero masks, and any change caused by those shows up on `mode_o`.

// File: rtl/setclr_mode_pkg.sv
package setclr_mode_pkg;
   localparam int unsigned BIT_START = 0;
   localparam int unsigned BIT_EOI   = 1;
   localparam int unsigned BIT_OFFL  = 2;
   localparam int unsigned BIT_LEAVE = 3;
   localparam int unsigned BIT_SWAP  = 4;
   localparam int unsigned BIT_WDRL  = 5;
   localparam int unsigned MIN_BITS  = 6;

   typedef struct packed {
      logic wd_reload;
      logic leave;
      logic eoi;
      logic start;
   } strobe_t;
endpackage

// File: rtl/setclr_decode.sv
module setclr_decode #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] SET_ADDR = 'h08,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 'h09
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] set_mask,
   output logic [DATA_W-1:0] clr_mask
);
   if (SET_ADDR == CLR_ADDR) begin : g_addr_clash
      $error("set and clear addresses must differ");
   end

   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      if (wr && addr == SET_ADDR) set_mask = wdata;
      if (wr && addr == CLR_ADDR) clr_mask = wdata;
   end
endmodule

// File: rtl/setclr_bank.sv
module setclr_bank #(
   parameter int unsigned WIDTH = 8,
   parameter logic [WIDTH-1:0] IMPL_MASK = 'h3F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_mask,
   input  logic [WIDTH-1:0] clr_mask,
   input  logic [WIDTH-1:0] done_mask,
   output logic [WIDTH-1:0] q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_impl
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= ((bit_q & ~done_mask[i]) | set_mask[i]) & ~clr_mask[i];
         end
         assign q[i] = bit_q;
      end else begin : g_resv
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/setclr_sequencer.sv
module setclr_sequencer
   import setclr_mode_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned WD_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] mode_q,
   input  logic             busy_i,
   input  logic [WD_W-1:0]  wd_preset_i,
   output logic [WIDTH-1:0] done_mask,
   output logic             online,
   output strobe_t          strobes,
   output logic [WD_W-1:0]  wd_value
);
   logic offl_fire;
   assign offl_fire = mode_q[BIT_OFFL] & ~busy_i;

   always_comb begin
      done_mask            = '0;
      done_mask[BIT_START] = mode_q[BIT_START];
      done_mask[BIT_EOI]   = mode_q[BIT_EOI];
      done_mask[BIT_OFFL]  = mode_q[BIT_START] | offl_fire;
      done_mask[BIT_LEAVE] = mode_q[BIT_LEAVE];
      done_mask[BIT_WDRL]  = mode_q[BIT_WDRL];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         online   <= 1'b0;
         strobes  <= '0;
         wd_value <= '0;
      end else begin
         strobes.start     <= mode_q[BIT_START];
         strobes.eoi       <= mode_q[BIT_EOI];
         strobes.leave     <= mode_q[BIT_LEAVE];
         strobes.wd_reload <= mode_q[BIT_WDRL];
         if (mode_q[BIT_WDRL]) wd_value <= wd_preset_i;
         if (mode_q[BIT_START])  online <= 1'b1;
         else if (offl_fire)     online <= 1'b0;
      end
   end

   p_offline_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(online) |-> !$past(busy_i));
endmodule

// File: rtl/setclr_mode_ctrl.sv
module setclr_mode_ctrl
   import setclr_mode_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WD_W   = 16,
   parameter logic [ADDR_W-1:0] SET_ADDR = 'h08,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 'h09
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              busy_i,
   input  logic              cfg_ok_i,
   input  logic [WD_W-1:0]   wd_preset_i,
   output logic [DATA_W-1:0] mode_o,
   output logic              online_o,
   output logic              timer_start_o,
   output logic              eoi_o,
   output logic              leave_master_o,
   output logic              wd_reload_o,
   output logic [WD_W-1:0]   wd_value_o,
   output logic              cfg_swap_o
);
   localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((1 << MIN_BITS) - 1);

   if (DATA_W < MIN_BITS) begin : g_narrow
      $error("data width too small for the command bits");
   end

   logic [DATA_W-1:0] set_mask, clr_mask, done_mask, mode_q;
   strobe_t           strobes;

   setclr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
      .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .set_mask(set_mask), .clr_mask(clr_mask));

   setclr_bank #(.WIDTH(DATA_W), .IMPL_MASK(IMPL_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
      .done_mask(done_mask), .q(mode_q));

   setclr_sequencer #(.WIDTH(DATA_W), .WD_W(WD_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .busy_i(busy_i),
      .wd_preset_i(wd_preset_i), .done_mask(done_mask), .online(online_o),
      .strobes(strobes), .wd_value(wd_value_o));

   assign mode_o         = mode_q;
   assign timer_start_o  = strobes.start;
   assign eoi_o          = strobes.eoi;
   assign leave_master_o = strobes.leave;
   assign wd_reload_o    = strobes.wd_reload;
   assign cfg_swap_o     = cfg_ok_i & mode_q[BIT_SWAP];

   p_start_goes_online_r5: assert property (@(posedge clk) disable iff (!rst_n)
      timer_start_o |-> online_o);

   p_eoi_self_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[BIT_EOI] && !set_mask[BIT_EOI]) |=> !mode_q[BIT_EOI]);

   p_leave_follows_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      leave_master_o |-> $past(mode_q[BIT_LEAVE]));

   p_offline_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[BIT_OFFL] && busy_i && !mode_q[BIT_START] && !clr_mask[BIT_OFFL])
      |=> (mode_q[BIT_OFFL] && $stable(online_o)));
endmodule

// File: tb/setclr_mode_ctrl_test.sv
module setclr_mode_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        busy_i = 1'b0;
   logic        cfg_ok_i = 1'b0;
   logic [15:0] wd_preset_i = '0;
   logic [7:0]  mode_o;
   logic        online_o, timer_start_o, eoi_o, leave_master_o, wd_reload_o, cfg_swap_o;
   logic [15:0] wd_value_o;

   int errors = 0;
   int checks = 0;
   logic [3:0] exp_q[$];

   always #2 clk = ~clk;

   setclr_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .busy_i(busy_i), .cfg_ok_i(cfg_ok_i),
      .wd_preset_i(wd_preset_i), .mode_o(mode_o), .online_o(online_o),
      .timer_start_o(timer_start_o), .eoi_o(eoi_o), .leave_master_o(leave_master_o),
      .wd_reload_o(wd_reload_o), .wd_value_o(wd_value_o), .cfg_swap_o(cfg_swap_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: one-cycle write, expected strobe pattern queued for the monitor
   task automatic host_write(input logic [7:0] a, input logic [7:0] d, input logic [3:0] exp_strb);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      if (exp_strb != 4'b0) exp_q.push_back(exp_strb);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // Monitor: each strobe pattern {wd_reload, leave, eoi, start} is popped and compared
   always @(negedge clk) begin
      logic [3:0] got;
      got = {wd_reload_o, leave_master_o, eoi_o, timer_start_o};
      if (rst_n && got != 4'b0) begin
         if (exp_q.size() == 0) check("R5-R8 unexpected strobe", {28'b0, got}, 32'h0);
         else check("R5-R8 strobe", {28'b0, got}, {28'b0, exp_q.pop_front()});
      end
   end

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            check("R4 mode", mode_o, 8'h00);
            check("R4 online", online_o, 1'b0);
            check("R4 strobes", {wd_reload_o, leave_master_o, eoi_o, timer_start_o}, 4'h0);

            host_write(8'h08, 8'h10, 4'h0);
            check("R1 set bit4", mode_o, 8'h10);
            cfg_ok_i = 1'b1; #1;
            check("R10 swap enabled", cfg_swap_o, 1'b1);
            cfg_ok_i = 1'b0;
            host_write(8'h09, 8'h00, 4'h0);
            check("R2 zero clear mask", mode_o, 8'h10);
            host_write(8'h09, 8'hEF, 4'h0);
            check("R2 clear keeps zero positions", mode_o, 8'h10);
            host_write(8'h08, 8'hC0, 4'h0);
            check("R3 reserved bits", mode_o, 8'h10);
            host_write(8'h0A, 8'hFF, 4'h0);
            check("R3 stray address", mode_o, 8'h10);

            host_write(8'h08, 8'h01, 4'b0001);
            check("R5 start bit set", mode_o, 8'h11);
            @(negedge clk);
            check("R5 online", online_o, 1'b1);
            check("R5 start bit cleared", mode_o, 8'h10);

            host_write(8'h08, 8'h02, 4'b0010);
            check("R6 eoi bit set", mode_o, 8'h12);
            @(negedge clk);
            check("R6 eoi bit cleared", mode_o, 8'h10);

            host_write(8'h08, 8'h08, 4'b0100);
            @(negedge clk);
            check("R7 leave bit cleared", mode_o, 8'h10);

            wd_preset_i = 16'hBEEF;
            host_write(8'h08, 8'h20, 4'b1000);
            @(negedge clk);
            check("R8 reload value", wd_value_o, 16'hBEEF);
            check("R8 reload bit cleared", mode_o, 8'h10);

            // R11: host sets eoi again in the cycle the block clears it
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 8'h02;
            exp_q.push_back(4'b0010); exp_q.push_back(4'b0010);
            @(negedge clk);
            @(negedge clk);
            bus_wr = 1'b0;
            check("R11 bit held by set", mode_o[1], 1'b1);
            @(negedge clk);
            check("R11 bit cleared after", mode_o[1], 1'b0);

            busy_i = 1'b1;
            host_write(8'h08, 8'h04, 4'h0);
            for (int i = 0; i < 5; i++) @(negedge clk);
            check("R9 pending bit", mode_o[2], 1'b1);
            check("R9 still online", online_o, 1'b1);
            busy_i = 1'b0;
            @(negedge clk);
            check("R9 offline", online_o, 1'b0);
            check("R9 bit cleared", mode_o[2], 1'b0);

            host_write(8'h08, 8'h01, 4'b0001);
            @(negedge clk);
            busy_i = 1'b1;
            host_write(8'h08, 8'h04, 4'h0);
            host_write(8'h08, 8'h01, 4'b0001);
            @(negedge clk);
            check("R5 start forces go-offline 0", mode_o[2], 1'b0);
            busy_i = 1'b0;
            repeat (3) @(negedge clk);
            check("R5 stays online", online_o, 1'b1);

            busy_i = 1'b1;
            host_write(8'h08, 8'h04, 4'h0);
            host_write(8'h09, 8'h04, 4'h0);
            check("R2 pending withdrawn", mode_o[2], 1'b0);
            busy_i = 1'b0;
            repeat (3) @(negedge clk);
            check("R2 online kept", online_o, 1'b1);

            host_write(8'h09, 8'h10, 4'h0);
            cfg_ok_i = 1'b1; #1;
            check("R10 swap disabled", cfg_swap_o, 1'b0);
            check("R10 mode", mode_o, 8'h00);
            cfg_ok_i = 1'b0;

            repeat (3) @(negedge clk);
            check("R5-R8 all strobes seen", exp_q.size(), 0);
         end
         begin
            repeat (200000) @(posedge clk);
            check("watchdog expired", 1, 0);
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule